// File: doc/BRIEF.md
# Page Write Collector with Deferred Commit

This block sits behind a serial-bus target front end on a byte-wide non-volatile store. The store holds 512 pages of 64 bytes. During a write transaction the front end first hands over a 16-bit address word and then streams data bytes. The block parks each byte in a 64-entry page buffer. It marks each position that receives a byte, and it moves its column pointer on inside the page only.

Nothing reaches the array until the front end reports the end of the transaction. The block then enters a busy window. First it scans the 64 buffer columns in ascending order, one column per clock. For each column that was loaded, it issues one write on the memory write port. It then waits a programmable number of timing ticks, which stands in for the long self-timed cell programming time. While busy is high, the block ignores every request from the front end. An abort throws away the collected bytes without starting a write cycle. The front end raises it when a repeated start arrives before any data, or when a write-protect rejection occurs.

Top module: `page_commit_top`

## Requirements
- R1: After reset, busy and mem_we are 0.
- R2: On a start-address load, bit 15 of the address word is ignored. Bits 14:6 set the page and bits 5:0 set the starting column. Every commit write carries that page in mem_addr[14:6] and the column in mem_addr[5:0].
- R3: Each accepted data byte advances the column pointer by one, modulo 64. The page does not change.
- R4: When more than 64 bytes are loaded, a later byte replaces the earlier one at the same column. Each column is written at most once, with the last value loaded there.
- R5: mem_we is 0 whenever busy is 0, so no byte reaches the array before the stop strobe.
- R6: A stop with at least one loaded column raises busy on the next cycle. It then scans the columns 0 to 63 over 64 cycles. mem_we is asserted only for loaded columns, in ascending column order.
- R7: After the scan, busy stays high until WAIT_TICKS tick pulses have been counted. Cycles without a tick extend the window.
- R8: While busy, the load, byte, stop and abort strobes have no effect. The page in progress is kept, and bytes offered during busy are not committed later.
- R9: An abort clears all loaded columns without raising busy. A byte offered in the same cycle as the abort is dropped.
- R10: A stop with no loaded column, and no byte in the same cycle, leaves busy at 0 and writes nothing.
- R11: A byte offered in the same cycle as the stop is loaded and is included in that commit.
- R12: A new start-address load discards the columns loaded before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_addr | input | 1 | Start-address load strobe |
| addr_word | input | 16 | Address word; bit 15 is ignored |
| byte_stb | input | 1 | Data byte strobe |
| byte_in | input | 8 | Data byte |
| stop_stb | input | 1 | End of write transaction |
| abort_stb | input | 1 | Discard the collected bytes |
| tick | input | 1 | Timing tick for the write-cycle wait |
| busy | output | 1 | Commit scan or wait in progress |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 15 | Array write address (page, column) |
| mem_wdata | output | 8 | Array write data |

## Verification
Two functions can land in the same clock edge. The final data byte can arrive together with the stop strobe, and a byte can arrive together with the abort strobe. The bench drives both strobes in one cycle. In the stop case, it checks that the commit contains that byte at the expected column. In the abort case, it follows with a plain stop and checks that busy stays low and that no write appears. Strobes driven during the busy window are judged in the same way: the bench counts the commit's writes and checks a later empty stop.

// File: rtl/pw_pkg.sv
package pw_pkg;
   typedef enum logic [1:0] {
      PW_IDLE = 2'd0,
      PW_SCAN = 2'd1,
      PW_WAIT = 2'd2
   } pw_state_e;
endpackage

// File: rtl/pw_ptr.sv
module pw_ptr #(
   parameter int PAGE_W = 9,
   parameter int COL_W  = 6,
   localparam int WORD_W = PAGE_W + COL_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] word,
   input  logic              adv,
   output logic [PAGE_W-1:0] page,
   output logic [COL_W-1:0]  col
);
   logic unused_top_bit;
   assign unused_top_bit = word[WORD_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page <= '0;
         col  <= '0;
      end else if (load) begin
         page <= word[WORD_W-2:COL_W];
         col  <= word[COL_W-1:0];
      end else if (adv) begin
         col  <= col + 1'b1;
      end
   end

   AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load) |=> (col == COL_W'($past(col) + 1'b1))); // R3
   AST_PAGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load) |=> $stable(page)); // R3
endmodule

// File: rtl/pw_buffer.sv
module pw_buffer #(
   parameter int COL_W  = 6,
   parameter int DATA_W = 8,
   localparam int DEPTH = 1 << COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [COL_W-1:0]  wr_col,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              clr,
   input  logic [COL_W-1:0]  rd_col,
   output logic [DATA_W-1:0] rd_data,
   output logic [DEPTH-1:0]  mask
);
   logic [DATA_W-1:0] ent_data [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic              vld_q;
      logic [DATA_W-1:0] dat_q;
      logic              hit;
      assign hit = wr_en && (wr_col == COL_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    vld_q <= 1'b0;
         else if (clr)  vld_q <= 1'b0;
         else if (hit)  vld_q <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (hit) dat_q <= wr_data;
      end

      assign mask[g]     = vld_q;
      assign ent_data[g] = dat_q;
   end

   assign rd_data = ent_data[rd_col];

   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (mask == '0)); // R9
   AST_LOAD_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr) |=> mask[$past(wr_col)]); // R4
endmodule

// File: rtl/pw_sequencer.sv
module pw_sequencer
   import pw_pkg::*;
#(
   parameter int COL_W      = 6,
   parameter int WAIT_TICKS = 5000,
   localparam int CNT_W = $clog2(WAIT_TICKS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             tick,
   output pw_state_e        state,
   output logic [COL_W-1:0] scan_col,
   output logic             done
);
   logic [CNT_W-1:0] cnt;
   logic             last_tick;

   assign last_tick = (cnt == CNT_W'(WAIT_TICKS - 1));
   assign done      = (state == PW_WAIT) && tick && last_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= PW_IDLE;
         scan_col <= '0;
         cnt      <= '0;
      end else begin
         unique case (state)
            PW_IDLE: if (go) begin
               state    <= PW_SCAN;
               scan_col <= '0;
            end
            PW_SCAN: begin
               scan_col <= scan_col + 1'b1;
               if (&scan_col) begin
                  state <= PW_WAIT;
                  cnt   <= '0;
               end
            end
            PW_WAIT: if (tick) begin
               cnt <= cnt + 1'b1;
               if (last_tick) state <= PW_IDLE;
            end
            default: state <= PW_IDLE;
         endcase
      end
   end

   AST_SCAN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PW_SCAN && &scan_col) |=> (state == PW_WAIT)); // R6
   AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PW_WAIT && !tick) |=> (state == PW_WAIT)); // R7
endmodule

// File: rtl/page_commit_top.sv
module page_commit_top
   import pw_pkg::*;
#(
   parameter int PAGE_W     = 9,
   parameter int COL_W      = 6,
   parameter int DATA_W     = 8,
   parameter int WAIT_TICKS = 5000,
   localparam int ADDR_W = PAGE_W + COL_W,
   localparam int WORD_W = ADDR_W + 1,
   localparam int DEPTH  = 1 << COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_addr,
   input  logic [WORD_W-1:0] addr_word,
   input  logic              byte_stb,
   input  logic [DATA_W-1:0] byte_in,
   input  logic              stop_stb,
   input  logic              abort_stb,
   input  logic              tick,
   output logic              busy,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata
);
   initial begin
      assert (WAIT_TICKS >= 1) else $error("WAIT_TICKS must be at least 1");
      assert (COL_W >= 1 && PAGE_W >= 1) else $error("address split invalid");
      assert (DATA_W >= 1) else $error("DATA_W must be positive");
   end

   pw_state_e         state;
   logic [PAGE_W-1:0] page;
   logic [COL_W-1:0]  col, scan_col;
   logic [DEPTH-1:0]  mask;
   logic [DATA_W-1:0] rd_data;
   logic              accept_byte, take_load, go, clr, done;

   assign busy        = (state != PW_IDLE);
   assign take_load   = ld_addr && !busy && !abort_stb;
   assign accept_byte = byte_stb && !busy && !abort_stb && !ld_addr;
   assign go          = stop_stb && !busy && !abort_stb && !ld_addr
                        && ((|mask) || accept_byte);
   assign clr         = done || (!busy && (abort_stb || ld_addr));

   pw_ptr #(.PAGE_W(PAGE_W), .COL_W(COL_W)) i_ptr (
      .clk(clk), .rst_n(rst_n), .load(take_load), .word(addr_word),
      .adv(accept_byte), .page(page), .col(col)
   );

   pw_buffer #(.COL_W(COL_W), .DATA_W(DATA_W)) i_buf (
      .clk(clk), .rst_n(rst_n), .wr_en(accept_byte), .wr_col(col),
      .wr_data(byte_in), .clr(clr), .rd_col(scan_col),
      .rd_data(rd_data), .mask(mask)
   );

   pw_sequencer #(.COL_W(COL_W), .WAIT_TICKS(WAIT_TICKS)) i_seq (
      .clk(clk), .rst_n(rst_n), .go(go), .tick(tick),
      .state(state), .scan_col(scan_col), .done(done)
   );

   assign mem_we    = (state == PW_SCAN) && mask[scan_col];
   assign mem_addr  = {page, scan_col};
   assign mem_wdata = rd_data;

   AST_NO_WE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_we); // R5
   AST_ABORT_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && abort_stb) |=> !busy); // R9
   AST_EMPTY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && stop_stb && !byte_stb && (mask == '0)) |=> !busy); // R10
   AST_STOP_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && stop_stb && !abort_stb && !ld_addr && byte_stb) |=> busy); // R11
   AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(page)); // R8
   AST_SCAN_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |-> (mem_addr[COL_W-1:0] > $past(mem_addr[COL_W-1:0]))); // R6
endmodule

// File: tb/test_page_commit_top.sv
module test_page_commit_top;
   localparam int W = 10;

   logic        clk = 0, rst_n = 0;
   logic        ld_addr = 0, byte_stb = 0, stop_stb = 0, abort_stb = 0, tick = 1;
   logic [15:0] addr_word = 0;
   logic [7:0]  byte_in = 0;
   logic        busy, mem_we;
   logic [14:0] mem_addr;
   logic [7:0]  mem_wdata;

   int n_chk = 0, n_bad = 0;
   int got_n = 0, early_we = 0;
   logic [14:0] got_a [64];
   logic [7:0]  got_d [64];
   bit          exp_v [64];
   logic [7:0]  exp_d [64];

   always #5 clk = ~clk;

   page_commit_top #(.WAIT_TICKS(W)) i_page_commit_top (
      .clk(clk), .rst_n(rst_n), .ld_addr(ld_addr), .addr_word(addr_word),
      .byte_stb(byte_stb), .byte_in(byte_in), .stop_stb(stop_stb),
      .abort_stb(abort_stb), .tick(tick), .busy(busy), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata)
   );

   always @(negedge clk) begin
      if (mem_we && !busy) early_we++;
      if (mem_we && got_n < 64) begin
         got_a[got_n] = mem_addr;
         got_d[got_n] = mem_wdata;
         got_n++;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive(input logic l, input logic [15:0] w, input logic b,
                        input logic [7:0] d, input logic s, input logic a);
      @(negedge clk);
      ld_addr = l; addr_word = w; byte_stb = b; byte_in = d;
      stop_stb = s; abort_stb = a;
   endtask

   task automatic quiet();
      drive(0, 16'h0, 0, 8'h0, 0, 0);
   endtask

   task automatic model_clear();
      for (int i = 0; i < 64; i++) exp_v[i] = 0;
      got_n = 0;
   endtask

   task automatic model_load(input logic [15:0] w, input int n, input logic [7:0] seed);
      for (int i = 0; i < n; i++) begin
         exp_v[(int'(w[5:0]) + i) % 64] = 1;
         exp_d[(int'(w[5:0]) + i) % 64] = seed + 8'(i);
      end
   endtask

   task automatic wait_idle(output int cyc);
      cyc = 0;
      while (busy && cyc < 5000) begin
         cyc++;
         @(negedge clk);
      end
   endtask

   task automatic judge(input logic [8:0] pg, input string req);
      int cnt = 0, bad = 0;
      for (int i = 0; i < 64; i++) if (exp_v[i]) cnt++;
      check(got_n == cnt, {req, " write count"}, got_n, cnt);
      for (int k = 0; k < got_n; k++) begin
         if (got_a[k][14:6] != pg) bad++;
         if (!exp_v[got_a[k][5:0]] || got_d[k] != exp_d[got_a[k][5:0]]) bad++;
         if (k > 0 && got_a[k][5:0] <= got_a[k-1][5:0]) bad++;
      end
      check(bad == 0, {req, " R6 contents/order"}, bad, 0);
   endtask

   // word, byte count, first data value
   localparam logic [31:0] VEC [5] = '{
      {16'h0000, 8'd1,  8'h11},   // R2 single byte
      {16'h817C, 8'd8,  8'h20},   // R2 top bit ignored, R3 wrap from col 60
      {16'h7FFF, 8'd3,  8'h40},   // R3 last page, wrap from col 63
      {16'h0040, 8'd70, 8'h80},   // R4 overwrite beyond 64
      {16'h1234, 8'd64, 8'h05}    // R6 full page
   };

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int cyc;
      repeat (3) @(negedge clk);
      check(busy == 0 && mem_we == 0, "R1 reset outputs", {busy, mem_we}, 0);
      rst_n = 1;
      @(negedge clk);

      foreach (VEC[v]) begin
         logic [15:0] w = VEC[v][31:16];
         int n = int'(VEC[v][15:8]);
         logic [7:0] seed = VEC[v][7:0];
         model_clear();
         model_load(w, n, seed);
         drive(1, w, 0, 0, 0, 0);
         for (int i = 0; i < n; i++) drive(0, 0, 1, seed + 8'(i), 0, 0);
         drive(0, 0, 0, 0, 1, 0);
         quiet();
         check(busy == 1, "R6 busy after stop", busy, 1);
         wait_idle(cyc);
         check(cyc == 64 + W, "R7 busy window", cyc, 64 + W);
         judge(w[14:6], "R2 R3 R4 vector");
      end
      check(early_we == 0, "R5 no write while idle", early_we, 0);

      // R11 byte together with stop
      model_clear();
      model_load(16'h0283, 3, 8'hA0);
      drive(1, 16'h0283, 0, 0, 0, 0);
      drive(0, 0, 1, 8'hA0, 0, 0);
      drive(0, 0, 1, 8'hA1, 0, 0);
      drive(0, 0, 1, 8'hA2, 1, 0);
      quiet();
      wait_idle(cyc);
      judge(9'h00A, "R11 stop+byte");

      // R9 abort with a byte in the same cycle, then stop
      model_clear();
      drive(1, 16'h0100, 0, 0, 0, 0);
      drive(0, 0, 1, 8'h55, 0, 0);
      drive(0, 0, 1, 8'h56, 0, 1);
      drive(0, 0, 0, 0, 1, 0);
      quiet();
      check(busy == 0, "R9 abort no busy", busy, 0);
      repeat (70) @(negedge clk);
      check(got_n == 0, "R9 abort no writes", got_n, 0);

      // R10 stop with nothing loaded
      drive(1, 16'h0200, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 1, 0);
      quiet();
      check(busy == 0, "R10 empty stop", busy, 0);

      // R12 reload discards earlier bytes
      model_clear();
      model_load(16'h004A, 2, 8'h70);
      drive(1, 16'h0011, 0, 0, 0, 0);
      for (int i = 0; i < 3; i++) drive(0, 0, 1, 8'h31, 0, 0);
      drive(1, 16'h004A, 0, 0, 0, 0);
      drive(0, 0, 1, 8'h70, 0, 0);
      drive(0, 0, 1, 8'h71, 0, 0);
      drive(0, 0, 0, 0, 1, 0);
      quiet();
      wait_idle(cyc);
      judge(9'h001, "R12 reload");

      // R8 strobes during busy, R7 missing ticks hold busy
      model_clear();
      model_load(16'h0C00, 2, 8'hE0);
      tick = 0;
      drive(1, 16'h0C00, 0, 0, 0, 0);
      drive(0, 0, 1, 8'hE0, 0, 0);
      drive(0, 0, 1, 8'hE1, 0, 0);
      drive(0, 0, 0, 0, 1, 0);
      drive(1, 16'h3F05, 0, 0, 0, 0);
      for (int i = 0; i < 4; i++) drive(0, 0, 1, 8'h99, 0, 0);
      drive(0, 0, 0, 0, 1, 1);
      quiet();
      repeat (150) @(negedge clk);
      check(busy == 1, "R7 busy held without ticks", busy, 1);
      tick = 1;
      wait_idle(cyc);
      check(cyc == W, "R7 wait after ticks resume", cyc, W);
      judge(9'h030, "R8 busy strobes");
      got_n = 0;
      drive(0, 0, 0, 0, 1, 0);
      quiet();
      check(busy == 0, "R8 bytes from busy not kept", busy, 0);
      repeat (70) @(negedge clk);
      check(got_n == 0, "R8 no stray writes", got_n, 0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule